// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for 32 pins. The pins are grouped into four banks of eight. A plain single-cycle register port reaches each bank through its own 64-byte window.

Each bank holds the following state:
- a direction register and an output data register;
- a read-only view of its pins after a two-flop synchronizer;
- an interrupt status register, an interrupt mask and a per-pin level/edge selection.

The controller drives the pin output values and the per-pin output enables. It also raises one combined interrupt line.

Software picks each pin as input or output (a direction bit of 1 means input). It writes output values and reads back the synchronized pin levels. It arms interrupts by clearing mask bits through a dedicated unmask address. A pin in edge mode latches a status bit on a rising input. A pin in level mode keeps its status bit set for as long as the input stays high. Status bits are cleared by writing ones to them.

Top module: `gpio_sect_ctrl`

## Requirements
- R1: Address bits [7:6] select the bank and bits [5:0] the register within the bank. Pin p lives in bank p>>3 at bit p&7. Read data carries the bank register in bits [7:0], and bits [31:8] always read 0.
- R2: After reset every pin is an input (all output enables 0), all output values are 0, every mask bit is 1, status is 0, every pin is edge-triggered and the interrupt line is 0.
- R3: Offset 0x10 is direction, where 1 means input and 0 means output. A pin's output enable is the inverse of its direction bit. Offset 0x14 is output data, which drives the pin outputs. Both registers read back what was written, and both take effect on the clock edge that captures the write.
- R4: Offset 0x18 reads the bank's pin inputs after a two-flop synchronizer. Writes to it are ignored.
- R5: A pin in edge mode sets its status bit (read raw at offset 0x04) on a rising edge of its synchronized input. A falling edge does not set it, and neither does an input that stays high.
- R6: Writing offset 0x04 clears every status bit written as 1 and leaves bits written as 0 unchanged. A set condition in the same cycle as a clear wins.
- R7: Writing offset 0x08 sets every mask bit written as 1. Writing offset 0x0C clears every mask bit written as 1. A read of 0x08 returns the mask, and a read of 0x0C returns 0.
- R8: Offset 0x00 reads status AND NOT mask. Writes to it are ignored.
- R9: Writing offset 0x20 makes every pin written as 1 level-triggered, and a read returns the selection. Writing 0 never returns a pin to edge mode. A level pin's status bit cannot be cleared while its synchronized input is high, but the clear takes effect once the input is low.
- R10: The interrupt output is the OR of all masked status bits across all banks, registered one cycle after the status.
- R11: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20 read as 0, and writes to them are ignored.
- R12: Read data appears in the cycle after the read request and is 0 in any cycle following a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address: bank in [7:6], register in [5:0] |
| bus_wdata | input | 32 | Write data; bits [7:0] are used |
| bus_rdata | output | 32 | Registered read data |
| pins_in | input | 32 | Asynchronous pin input levels |
| pins_out | output | 32 | Pin output values |
| pins_oe | output | 32 | Pin output enables, 1 = drive |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each result has a fixed latency after its stimulus:
- Register writes take effect on the edge that captures them.
- Read data is due one edge after the read strobe.
- A pin change reaches the input view after two edges and the status register after three.
- The interrupt line follows the status one edge later, so it is due four edges after a pin change.

The bench drives on falling edges and samples on the falling edge after the due edge. For the interrupt line it also samples one cycle early to confirm the line has not moved yet. For reads, the driver queues the expected word as it issues the request. The monitor pops the queue on the falling edge after any cycle in which a read was strobed, so each comparison lines up with its one-cycle read latency.

// File: rtl/gpio_sect_pkg.sv
package gpio_sect_pkg;
  localparam int WIN_BITS = 6;
  localparam logic [WIN_BITS-1:0] REG_MSTAT = 6'h00;
  localparam logic [WIN_BITS-1:0] REG_RSTAT = 6'h04;
  localparam logic [WIN_BITS-1:0] REG_MSET  = 6'h08;
  localparam logic [WIN_BITS-1:0] REG_MCLR  = 6'h0C;
  localparam logic [WIN_BITS-1:0] REG_DIR   = 6'h10;
  localparam logic [WIN_BITS-1:0] REG_DOUT  = 6'h14;
  localparam logic [WIN_BITS-1:0] REG_DIN   = 6'h18;
  localparam logic [WIN_BITS-1:0] REG_LVL   = 6'h20;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/gpio_sect_irq.sv
module gpio_sect_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_sync,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;
  logic [W-1:0] set_vec;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (lvl_sel[i]) set_vec[i] = in_sync[i];
      else            set_vec[i] = in_sync[i] & ~prev_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= in_sync;
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign status = stat_q;

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    1 |=> (((stat_q & ~$past(stat_q)) & ~$past(in_sync)) == '0)) // R5
    else $error("status bit set without a high input");

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((stat_q & $past(lvl_sel & in_sync)) == $past(lvl_sel & in_sync))) // R9
    else $error("level pin status dropped while input high");

  AST_FALL_NO_SET: assert property (@(posedge clk) disable iff (rst)
    1 |=> (((stat_q & ~$past(stat_q)) & ~$past(lvl_sel) & $past(prev_q)) == '0)) // R5
    else $error("edge pin status set without a rising edge");
endmodule

// File: rtl/gpio_sect_bank.sv
module gpio_sect_bank
  import gpio_sect_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] offset,
  input  logic [W-1:0]        wdata,
  input  logic [W-1:0]        pin_raw,
  output logic [W-1:0]        rd_data,
  output logic [W-1:0]        dout,
  output logic [W-1:0]        oe,
  output logic [W-1:0]        masked
);
  logic [W-1:0] dir_q;
  logic [W-1:0] dout_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] lvl_q;
  logic [W-1:0] in_sync;
  logic [W-1:0] status;
  logic [W-1:0] clr_vec;

  gpio_sync2 #(.W(W)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .d_async (pin_raw),
    .d_sync  (in_sync)
  );

  assign clr_vec = (wr_en && offset == REG_RSTAT) ? wdata : '0;

  gpio_sect_irq #(.W(W)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .in_sync (in_sync),
    .lvl_sel (lvl_q),
    .clr_vec (clr_vec),
    .status  (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      dout_q <= '0;
      mask_q <= '1;
      lvl_q  <= '0;
    end else if (wr_en) begin
      case (offset)
        REG_DIR:  dir_q  <= wdata;
        REG_DOUT: dout_q <= wdata;
        REG_MSET: mask_q <= mask_q | wdata;
        REG_MCLR: mask_q <= mask_q & ~wdata;
        REG_LVL:  lvl_q  <= lvl_q | wdata;
        default:  ;
      endcase
    end
  end

  assign masked = status & ~mask_q;
  assign dout   = dout_q;
  assign oe     = ~dir_q;

  always_comb begin
    case (offset)
      REG_MSTAT: rd_data = masked;
      REG_RSTAT: rd_data = status;
      REG_MSET:  rd_data = mask_q;
      REG_DIR:   rd_data = dir_q;
      REG_DOUT:  rd_data = dout_q;
      REG_DIN:   rd_data = in_sync;
      REG_LVL:   rd_data = lvl_q;
      default:   rd_data = '0;
    endcase
  end

  AST_LEVEL_ONLY_GROWS: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((lvl_q & $past(lvl_q)) == $past(lvl_q))) // R9
    else $error("level selection bit returned to edge");

  AST_MASK_SET_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offset == REG_MSET) |=> ((mask_q & $past(wdata)) == $past(wdata))) // R7
    else $error("mask set write did not set bits");

  AST_MASK_CLR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && offset == REG_MCLR) |=> ((mask_q & $past(wdata)) == '0)) // R7
    else $error("unmask write did not clear bits");
endmodule

// File: rtl/gpio_sect_ctrl.sv
module gpio_sect_ctrl
  import gpio_sect_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 8,
  parameter int DATA_W    = 32,
  localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = WIN_BITS + SEL_W,
  localparam int NPINS    = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pins_in,
  output logic [NPINS-1:0]  pins_out,
  output logic [NPINS-1:0]  pins_oe,
  output logic              irq_out
);
  logic [SEL_W-1:0]    sel;
  logic [WIN_BITS-1:0] offset;
  logic [BANK_W-1:0]   bank_rd [NUM_BANKS];
  logic [NPINS-1:0]    masked_all;
  logic [DATA_W-1:0]   rdata_q;
  logic                irq_q;

  assign sel    = bus_addr[ADDR_W-1:WIN_BITS];
  assign offset = bus_addr[WIN_BITS-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && (sel == SEL_W'(b));

    gpio_sect_bank #(.W(BANK_W)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_wr),
      .offset  (offset),
      .wdata   (bus_wdata[BANK_W-1:0]),
      .pin_raw (pins_in[b*BANK_W +: BANK_W]),
      .rd_data (bank_rd[b]),
      .dout    (pins_out[b*BANK_W +: BANK_W]),
      .oe      (pins_oe[b*BANK_W +: BANK_W]),
      .masked  (masked_all[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |masked_all;
      if (bus_rd && (int'(sel) < NUM_BANKS)) rdata_q <= DATA_W'(bank_rd[sel]);
      else                                  rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1 |=> (irq_out == $past(|masked_all))) // R10
    else $error("interrupt line does not follow masked status");

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0)) // R12
    else $error("read data nonzero after idle cycle");

  AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (rst)
    1 |=> (bus_rdata[DATA_W-1:BANK_W] == '0)) // R1
    else $error("upper read data bits nonzero");
endmodule

// File: tb/gpio_sect_ctrl_tb_top.sv
module gpio_sect_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins_in = '0;
  logic [31:0] pins_out;
  logic [31:0] pins_oe;
  logic        irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sect_ctrl dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pins_in   (pins_in),
    .pins_out  (pins_out),
    .pins_oe   (pins_oe),
    .irq_out   (irq_out)
  );

  // monitor: one expected item per strobed read
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL scoreboard: read data %h with nothing expected", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (bus_rdata !== e) begin
          n_fails++;
          $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_checks++;
    if (act !== e) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2 oe", pins_oe, 32'h0);
    chk("R2 out", pins_out, 32'h0);
    chk("R2 irq", {31'b0, irq_out}, 32'h0);
    rd_exp(8'h08, 32'hFF, "R2 mask");
    rd_exp(8'h44, 32'h00, "R2 status");
    rd_exp(8'hE0, 32'h00, "R2 level");
    rd_exp(8'h90, 32'hFF, "R2 dir");

    // R12 idle read data is zero
    idle(1);
    chk("R12 idle rdata", bus_rdata, 32'h0);

    // R1 / R3 bank addressing and output path
    wr(8'hD4, 32'hFFFF_FFA5);
    chk("R1 R3 out bank3", pins_out, 32'hA500_0000);
    rd_exp(8'hD4, 32'hA5, "R1 upper bits zero");
    wr(8'h90, 32'h0F);
    chk("R3 oe bank2", pins_oe, 32'h00F0_0000);
    rd_exp(8'h90, 32'h0F, "R3 dir readback");
    wr(8'h90, 32'hFF);
    chk("R3 oe restored", pins_oe, 32'h0);

    // R4 input view and ignored write
    pins_in = 32'h005A_3C00;
    idle(3);
    rd_exp(8'h58, 32'h3C, "R4 input bank1");
    rd_exp(8'h98, 32'h5A, "R4 input bank2");
    wr(8'h58, 32'hFF);
    rd_exp(8'h58, 32'h3C, "R4 write ignored");
    pins_in = 32'h0;
    idle(4);
    wr(8'h44, 32'hFF);
    wr(8'h84, 32'hFF);
    rd_exp(8'h44, 32'h00, "R6 cleared bank1");

    // R5 edge detection on pin 0
    pins_in[0] = 1'b1;
    idle(4);
    rd_exp(8'h04, 32'h01, "R5 rising edge sets");
    wr(8'h04, 32'h01);
    idle(3);
    rd_exp(8'h04, 32'h00, "R5 steady high no set");
    pins_in[0] = 1'b0;
    idle(4);
    rd_exp(8'h04, 32'h00, "R5 falling no set");

    // R6 selective clear
    pins_in[2:1] = 2'b11;
    idle(4);
    rd_exp(8'h04, 32'h06, "R6 two set");
    wr(8'h04, 32'h02);
    rd_exp(8'h04, 32'h04, "R6 selective clear");

    // R7 / R8 / R10 mask and interrupt
    rd_exp(8'h00, 32'h00, "R8 all masked");
    wr(8'h0C, 32'h04);
    rd_exp(8'h08, 32'hFB, "R7 unmask");
    rd_exp(8'h0C, 32'h00, "R7 unmask reads zero");
    rd_exp(8'h00, 32'h04, "R8 masked status");
    chk("R10 irq raised", {31'b0, irq_out}, 32'h1);
    wr(8'h00, 32'hFF);
    rd_exp(8'h04, 32'h04, "R8 write ignored");
    wr(8'h08, 32'h04);
    chk("R10 irq one cycle late", {31'b0, irq_out}, 32'h1);
    idle(1);
    chk("R10 irq dropped", {31'b0, irq_out}, 32'h0);
    rd_exp(8'h08, 32'hFF, "R7 mask set");
    wr(8'h04, 32'hFF);
    pins_in[2:1] = 2'b00;

    // R10 exact latency from a pin edge on bank 3 pin 30
    wr(8'hCC, 32'h40);
    idle(2);
    pins_in[30] = 1'b1;
    idle(3);
    chk("R10 irq not before 4 edges", {31'b0, irq_out}, 32'h0);
    idle(1);
    chk("R10 irq after 4 edges", {31'b0, irq_out}, 32'h1);
    wr(8'hC4, 32'h40);
    idle(1);
    chk("R10 irq cleared", {31'b0, irq_out}, 32'h0);
    pins_in[30] = 1'b0;

    // R9 level mode on pin 9
    wr(8'h60, 32'h02);
    rd_exp(8'h60, 32'h02, "R9 level readback");
    wr(8'h60, 32'h00);
    rd_exp(8'h60, 32'h02, "R9 zero write keeps level");
    pins_in[9] = 1'b1;
    idle(4);
    rd_exp(8'h44, 32'h02, "R9 level sets");
    wr(8'h44, 32'h02);
    rd_exp(8'h44, 32'h02, "R9 clear blocked while high");
    pins_in[9] = 1'b0;
    idle(4);
    wr(8'h44, 32'h02);
    rd_exp(8'h44, 32'h00, "R9 clear after low");

    // R11 unused offsets
    wr(8'h5C, 32'hFF);
    rd_exp(8'h5C, 32'h00, "R11 unused reads zero");
    rd_exp(8'h3C, 32'h00, "R11 unused high offset");
    chk("R11 outputs untouched", pins_out, 32'hA500_0000);

    idle(2);
    finish_run();
  end
endmodule